// File: doc/BRIEF.md
# Capacitive Key Touch Decision Engine

This block turns raw per-channel acquisition results into debounced touch flags for a bank of capacitive keys. On every acquisition it takes one measured count and one baseline count per channel. It derives how far each measurement has fallen below its baseline and compares that depth against a per-key threshold. A key is reported as touched only after a run of qualifying acquisitions. Keys in one shared suppression group compete, so only the member with the deepest touch may be reported at a time.

The same acquisitions are checked for readings that move the wrong way, above the baseline. A run of such readings that lasts too long raises a sticky request for a full recalibration. Channels whose baseline count lies outside the usable burst range are shut off until the next calibration command. That command clears every integrator, flag and timer. Baseline tracking and drift correction live elsewhere; this engine only consumes their results.

Top module: `touch_detect_engine`

## Requirements
- R1: After reset, `detect`, `key_disabled` and `recal_req` are all zero.
- R2: A channel qualifies on an acquisition when its baseline exceeds its measurement by at least its own 8-bit threshold (touch depth = baseline − measurement). A depth below the threshold never produces a touch flag.
- R3: A touch flag rises on the acquisition that completes `di_count` consecutive qualifying acquisitions. A non-qualifying acquisition restarts the run. A `di_count` of zero acts as one.
- R4: A touch flag falls on the first non-qualifying acquisition.
- R5: Among channels whose `group_mask` bit is 1, at most one flag is set: the candidate with the greatest depth, with ties going to the lowest channel index. A member that is outranked drops at once and returns at once when it leads again. Channels outside the group are not affected.
- R6: A channel whose baseline is below 16 or above 1536 is marked in `key_disabled` on that acquisition. Its flag stays 0, and it stays disabled even after its baseline returns to range, until `cal_cmd`. Baselines of exactly 16 and 1536 are usable.
- R7: With `drift_mode` = 0 (relative tracking), an enabled channel is in error when its measurement exceeds its baseline by more than 4.
- R8: With `drift_mode` = 1 (normal tracking only), the error condition is 4·(measurement − baseline) > 3·threshold, that is, more than three quarters of the threshold.
- R9: `recal_req` is set on the acquisition where the count of consecutive acquisitions with any channel in error exceeds `recal_delay`. An error-free acquisition clears the count. Once set, `recal_req` stays set until `cal_cmd`.
- R10: `cal_cmd` clears all integrators, touch flags, disable marks, the error count and `recal_req`, and it takes priority over a simultaneous acquisition.
- R11: A touch that keeps qualifying stays flagged for as long as it lasts. Duration alone never clears it.
- R12: State changes only on cycles with `sample_valid` or `cal_cmd`. Outputs are registered and update one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One acquisition is presented this cycle |
| signal_flat | input | N_CH*CNT_W | Measured counts, channel i at bits [i*CNT_W +: CNT_W] |
| reference_flat | input | N_CH*CNT_W | Baseline counts, same packing |
| threshold_flat | input | N_CH*THR_W | Per-channel touch threshold, same packing |
| di_count | input | DI_W | Consecutive qualifying acquisitions required |
| group_mask | input | N_CH | 1 = channel belongs to the suppression group |
| drift_mode | input | 1 | 0 = relative tracking limit, 1 = normal tracking limit |
| recal_delay | input | DLY_W | Error run length tolerated before requesting recalibration |
| cal_cmd | input | 1 | Calibration command, clears the engine |
| detect | output | N_CH | Touch flags |
| key_disabled | output | N_CH | Channels shut off for an out-of-range burst length |
| recal_req | output | 1 | Sticky recalibration request |

## Verification
The bench checks the integrator run length at its boundaries: flag on the third qualifying acquisition but not the second, a broken run that must restart, and a zero count. An off-by-one or missing restart would flag early or late. It drives group contests where the deeper key must displace the current holder, a tie that must stay with the lower index, and an outsider that must stay untouched. An arbiter that latched its first winner or ignored the mask would show the wrong flags. It also probes the error limits at exactly 4 and at exactly three quarters of the threshold, and the burst range at 15/16 and 1536/1537. A strict-versus-inclusive slip would either fire the recalibration request too soon or disable a usable key. Finally, it places the calibration command in the same cycle as an acquisition, where a wrong priority would leave a flag or a partial integrator behind.

// File: rtl/tde_pkg.sv
package tde_pkg;

    typedef enum logic {
        DRIFT_RELATIVE = 1'b0,
        DRIFT_NORMAL   = 1'b1
    } drift_mode_e;

    // Away-from-touch tolerance used when relative tracking is active
    localparam int REL_AWAY_LIMIT = 4;

endpackage

// File: rtl/tde_key_eval.sv
module tde_key_eval
    import tde_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int THR_W     = 8,
    parameter int BURST_MIN = 16,
    parameter int BURST_MAX = 1536
) (
    input  logic [CNT_W-1:0] signal_cnt,
    input  logic [CNT_W-1:0] reference_cnt,
    input  logic [THR_W-1:0] threshold,
    input  drift_mode_e      drift,
    output logic [CNT_W-1:0] touch_depth,
    output logic             qualifies,
    output logic             away_error,
    output logic             burst_bad
);
    localparam logic [CNT_W-1:0] LO_LIMIT  = CNT_W'(BURST_MIN);
    localparam logic [CNT_W-1:0] HI_LIMIT  = CNT_W'(BURST_MAX);
    localparam logic [CNT_W-1:0] REL_LIMIT = CNT_W'(REL_AWAY_LIMIT);
    localparam int               EXT_W     = CNT_W + 2;

    logic             below;
    logic             above;
    logic [CNT_W-1:0] away_depth;
    logic [EXT_W-1:0] thr_ext;
    logic [EXT_W-1:0] thr_x3;
    logic [EXT_W-1:0] away_x4;

    always_comb begin
        below       = reference_cnt > signal_cnt;
        above       = signal_cnt > reference_cnt;
        touch_depth = below ? (reference_cnt - signal_cnt) : '0;
        away_depth  = above ? (signal_cnt - reference_cnt) : '0;
        qualifies   = below && (touch_depth >= CNT_W'(threshold));

        thr_ext = EXT_W'(threshold);
        thr_x3  = thr_ext + (thr_ext << 1);
        away_x4 = {away_depth, 2'b00};

        if (drift == DRIFT_NORMAL) begin
            away_error = away_x4 > thr_x3;
        end else begin
            away_error = away_depth > REL_LIMIT;
        end

        burst_bad = (reference_cnt < LO_LIMIT) || (reference_cnt > HI_LIMIT);
    end

endmodule

// File: rtl/tde_group_arb.sv
module tde_group_arb #(
    parameter int N_CH  = 6,
    parameter int CNT_W = 16
) (
    input  logic [N_CH-1:0]       candidates,
    input  logic [N_CH*CNT_W-1:0] depths_flat,
    output logic [N_CH-1:0]       winner
);
    logic [CNT_W-1:0] best_depth;
    logic             found;

    always_comb begin
        winner     = '0;
        best_depth = '0;
        found      = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            // strict compare keeps the lower index on equal depth
            if (candidates[i] &&
                (!found || depths_flat[i*CNT_W +: CNT_W] > best_depth)) begin
                found      = 1'b1;
                best_depth = depths_flat[i*CNT_W +: CNT_W];
                winner     = '0;
                winner[i]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/touch_detect_engine.sv
module touch_detect_engine
    import tde_pkg::*;
#(
    parameter int N_CH      = 6,
    parameter int CNT_W     = 16,
    parameter int THR_W     = 8,
    parameter int DI_W      = 8,
    parameter int DLY_W     = 8,
    parameter int BURST_MIN = 16,
    parameter int BURST_MAX = 1536
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_valid,
    input  logic [N_CH*CNT_W-1:0]   signal_flat,
    input  logic [N_CH*CNT_W-1:0]   reference_flat,
    input  logic [N_CH*THR_W-1:0]   threshold_flat,
    input  logic [DI_W-1:0]         di_count,
    input  logic [N_CH-1:0]         group_mask,
    input  logic                    drift_mode,
    input  logic [DLY_W-1:0]        recal_delay,
    input  logic                    cal_cmd,
    output logic [N_CH-1:0]         detect,
    output logic [N_CH-1:0]         key_disabled,
    output logic                    recal_req
);
    localparam int ERR_W = DLY_W + 1;

    typedef struct packed {
        logic [N_CH-1:0][DI_W-1:0] integ;
        logic [N_CH-1:0]           det;
        logic [N_CH-1:0]           dis;
        logic [ERR_W-1:0]          err_cnt;
        logic                      recal;
    } state_t;

    state_t state_d, state_q;

    logic [N_CH-1:0]       qual_raw;
    logic [N_CH-1:0]       away_raw;
    logic [N_CH-1:0]       burst_bad;
    logic [N_CH*CNT_W-1:0] depths_flat;
    logic [N_CH-1:0]       enabled;
    logic [N_CH-1:0]       qual;
    logic [N_CH-1:0]       cand;
    logic [N_CH-1:0]       grp_win;
    logic [DI_W-1:0]       di_eff;
    logic                  err_any;
    drift_mode_e           drift_sel;

    assign drift_sel = drift_mode_e'(drift_mode);

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_chan
            tde_key_eval #(
                .CNT_W    (CNT_W),
                .THR_W    (THR_W),
                .BURST_MIN(BURST_MIN),
                .BURST_MAX(BURST_MAX)
            ) u_eval (
                .signal_cnt   (signal_flat[g*CNT_W +: CNT_W]),
                .reference_cnt(reference_flat[g*CNT_W +: CNT_W]),
                .threshold    (threshold_flat[g*THR_W +: THR_W]),
                .drift        (drift_sel),
                .touch_depth  (depths_flat[g*CNT_W +: CNT_W]),
                .qualifies    (qual_raw[g]),
                .away_error   (away_raw[g]),
                .burst_bad    (burst_bad[g])
            );
        end
    endgenerate

    tde_group_arb #(
        .N_CH (N_CH),
        .CNT_W(CNT_W)
    ) u_arb (
        .candidates (cand & group_mask),
        .depths_flat(depths_flat),
        .winner     (grp_win)
    );

    // Per-channel qualification, integrator and candidate selection
    always_comb begin
        di_eff  = (di_count == '0) ? DI_W'(1) : di_count;
        enabled = ~state_q.dis & ~burst_bad;
        qual    = qual_raw & enabled;
        err_any = |(away_raw & enabled);
        cand    = '0;
        state_d = state_q;

        for (int i = 0; i < N_CH; i++) begin
            if (!qual[i]) begin
                state_d.integ[i] = '0;
            end else if (state_q.integ[i] >= di_eff) begin
                state_d.integ[i] = di_eff;
            end else begin
                state_d.integ[i] = state_q.integ[i] + DI_W'(1);
            end
            cand[i] = qual[i] && (state_q.det[i] || (state_d.integ[i] >= di_eff));
        end

        state_d.det = (cand & ~group_mask) | grp_win;
        state_d.dis = state_q.dis | burst_bad;

        if (err_any) begin
            if (state_q.err_cnt != '1) begin
                state_d.err_cnt = state_q.err_cnt + ERR_W'(1);
            end
        end else begin
            state_d.err_cnt = '0;
        end
        state_d.recal = state_q.recal ||
                        (err_any && (state_d.err_cnt > ERR_W'(recal_delay)));

        if (cal_cmd) begin
            state_d = '0;
        end else if (!sample_valid) begin
            state_d = state_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign detect       = state_q.det;
    assign key_disabled = state_q.dis;
    assign recal_req    = state_q.recal;

endmodule

// File: rtl/tde_checker.sv
module tde_checker #(
    parameter int N_CH = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_valid,
    input logic            cal_cmd,
    input logic [N_CH-1:0] group_mask,
    input logic [N_CH-1:0] detect,
    input logic [N_CH-1:0] key_disabled,
    input logic            recal_req
);
    // R12: outputs hold without a strobe
    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !cal_cmd) |=>
            ($stable(detect) && $stable(key_disabled) && $stable(recal_req)))
        else $error("R12 outputs changed without strobe");

    // R10: calibration clears everything
    a_r10_cal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cal_cmd |=> (detect == '0 && key_disabled == '0 && !recal_req))
        else $error("R10 calibration left state behind");

    // R5: at most one group member flagged
    a_r5_group_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(detect & group_mask))
        else $error("R5 several group members flagged");

    // R6: a disabled key never flags
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (detect & key_disabled) == '0)
        else $error("R6 disabled key flagged");

    // R6: disable marks only clear on calibration
    a_r6_disable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_cmd |=> ((key_disabled & $past(key_disabled)) == $past(key_disabled)))
        else $error("R6 disable mark dropped");

    // R9: request is sticky until calibration
    a_r9_recal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (recal_req && !cal_cmd) |=> recal_req)
        else $error("R9 recalibration request dropped");

endmodule

bind touch_detect_engine tde_checker #(.N_CH(N_CH)) u_tde_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .cal_cmd     (cal_cmd),
    .group_mask  (group_mask),
    .detect      (detect),
    .key_disabled(key_disabled),
    .recal_req   (recal_req)
);

// File: tb/touch_detect_engine_bench.sv
module touch_detect_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH  = 6;
    localparam int CNT_W = 16;
    localparam int THR_W = 8;
    localparam int DI_W  = 8;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic cal_cmd = 1'b0;
    logic [DI_W-1:0]  di_count = 8'd3;
    logic [N_CH-1:0]  group_mask = '0;
    logic             drift_mode = 1'b0;
    logic [DLY_W-1:0] recal_delay = 8'd200;

    logic [CNT_W-1:0] sig [N_CH];
    logic [CNT_W-1:0] rf  [N_CH];
    logic [THR_W-1:0] thr [N_CH];

    logic [N_CH*CNT_W-1:0] signal_flat;
    logic [N_CH*CNT_W-1:0] reference_flat;
    logic [N_CH*THR_W-1:0] threshold_flat;
    logic [N_CH-1:0] detect;
    logic [N_CH-1:0] key_disabled;
    logic            recal_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            signal_flat[i*CNT_W +: CNT_W]    = sig[i];
            reference_flat[i*CNT_W +: CNT_W] = rf[i];
            threshold_flat[i*THR_W +: THR_W] = thr[i];
        end
    end

    touch_detect_engine u_touch_detect_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_valid  (sample_valid),
        .signal_flat   (signal_flat),
        .reference_flat(reference_flat),
        .threshold_flat(threshold_flat),
        .di_count      (di_count),
        .group_mask    (group_mask),
        .drift_mode    (drift_mode),
        .recal_delay   (recal_delay),
        .cal_cmd       (cal_cmd),
        .detect        (detect),
        .key_disabled  (key_disabled),
        .recal_req     (recal_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        for (int i = 0; i < N_CH; i++) begin
            sig[i] = 16'd500;
            rf[i]  = 16'd500;
            thr[i] = 8'd10;
        end
    endtask

    // one acquisition; returns at the next falling edge with outputs updated
    task automatic sample(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample_valid = 1'b1;
            @(negedge clk);
            sample_valid = 1'b0;
        end
    endtask

    task automatic calibrate();
        @(negedge clk);
        cal_cmd = 1'b1;
        @(negedge clk);
        cal_cmd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 detect", 32'(detect), 32'h0);
        check("R1 disabled", 32'(key_disabled), 32'h0);
        check("R1 recal", 32'(recal_req), 32'h0);
    endtask

    task automatic t_integrator();
        set_idle();
        sig[0] = 16'd490;                  // depth 10 = threshold
        sample(2);
        check("R3 two samples short", 32'(detect), 32'h0);
        sample(1);
        check("R3 third sample flags", 32'(detect), 32'h1);
        sig[0] = 16'd500;
        sample(1);
        check("R4 single release", 32'(detect), 32'h0);
        sig[1] = 16'd491;                  // depth 9 below threshold
        sample(5);
        check("R2 below threshold", 32'(detect), 32'h0);
        sig[1] = 16'd500;
        sig[0] = 16'd490;
        sample(2);
        sig[0] = 16'd500;
        sample(1);
        sig[0] = 16'd490;
        sample(2);
        check("R3 broken run restarts", 32'(detect), 32'h0);
        sample(1);
        check("R3 restarted run flags", 32'(detect), 32'h1);
        sig[0] = 16'd500;
        sample(1);
        di_count = 8'd0;
        sig[2] = 16'd480;
        sample(1);
        check("R3 zero count acts as one", 32'(detect), 32'h4);
        di_count = 8'd3;
        set_idle();
        sample(1);
        calibrate();
    endtask

    task automatic t_hold_and_long();
        set_idle();
        sig[0] = 16'd470;
        repeat (10) @(negedge clk);
        check("R12 no strobe no flag", 32'(detect), 32'h0);
        sample(3);
        sample(50);
        check("R11 long touch stays", 32'(detect), 32'h1);
        sig[0] = 16'd500;
        repeat (5) @(negedge clk);
        check("R12 flag held without strobe", 32'(detect), 32'h1);
        sample(1);
        check("R4 release after hold", 32'(detect), 32'h0);
        calibrate();
    endtask

    task automatic t_group();
        set_idle();
        group_mask = 6'b000111;
        sig[0] = 16'd480;                  // depth 20
        sig[1] = 16'd470;                  // depth 30
        sig[3] = 16'd485;                  // depth 15, outside group
        sample(3);
        check("R5 deeper member wins", 32'(detect), 32'h0A);
        sig[0] = 16'd460;                  // depth 40
        sample(1);
        check("R5 takeover", 32'(detect), 32'h09);
        sig[1] = 16'd460;                  // tie at 40
        sample(1);
        check("R5 tie to lowest index", 32'(detect), 32'h09);
        sig[0] = 16'd500;
        sample(1);
        check("R5 displaced member returns", 32'(detect), 32'h0A);
        group_mask = '0;
        set_idle();
        sample(1);
        calibrate();
    endtask

    task automatic t_burst();
        set_idle();
        rf[2] = 16'd15;   sig[2] = 16'd0;
        rf[3] = 16'd16;   sig[3] = 16'd6;
        rf[4] = 16'd1537; sig[4] = 16'd1527;
        rf[5] = 16'd1536; sig[5] = 16'd1526;
        sample(1);
        check("R6 out of range marked", 32'(key_disabled), 32'h14);
        sample(2);
        check("R6 range edges usable", 32'(detect), 32'h28);
        rf[2] = 16'd500; sig[2] = 16'd490;
        rf[4] = 16'd500; sig[4] = 16'd490;
        sample(3);
        check("R6 stays disabled", 32'(detect), 32'h28);
        check("R6 marks kept", 32'(key_disabled), 32'h14);
        calibrate();
        check("R10 marks cleared", 32'(key_disabled), 32'h0);
        sample(3);
        check("R6 re-enabled after cal", 32'(detect), 32'h3C);
        set_idle();
        sample(1);
        calibrate();
    endtask

    task automatic t_away();
        set_idle();
        drift_mode  = 1'b0;
        recal_delay = 8'd2;
        sig[0] = 16'd504;                  // away 4: not an error
        sample(5);
        check("R7 limit not exceeded", 32'(recal_req), 32'h0);
        sig[0] = 16'd505;
        sample(2);
        sig[0] = 16'd500;
        sample(1);
        sig[0] = 16'd505;
        sample(2);
        check("R9 broken error run", 32'(recal_req), 32'h0);
        sample(1);
        check("R9 request after run", 32'(recal_req), 32'h1);
        sig[0] = 16'd500;
        sample(2);
        check("R9 request sticky", 32'(recal_req), 32'h1);
        calibrate();
        check("R10 request cleared", 32'(recal_req), 32'h0);
        drift_mode  = 1'b1;
        recal_delay = 8'd0;
        thr[0] = 8'd12;
        sig[0] = 16'd509;                  // 36 > 36 false
        sample(1);
        check("R8 three quarters not exceeded", 32'(recal_req), 32'h0);
        sig[0] = 16'd510;                  // 40 > 36
        sample(1);
        check("R8 above three quarters", 32'(recal_req), 32'h1);
        drift_mode  = 1'b0;
        recal_delay = 8'd200;
        set_idle();
        calibrate();
    endtask

    task automatic t_cal_priority();
        set_idle();
        sig[0] = 16'd480;
        sample(3);
        check("R3 flag before cal", 32'(detect), 32'h1);
        @(negedge clk);
        cal_cmd = 1'b1;
        sample_valid = 1'b1;
        @(negedge clk);
        cal_cmd = 1'b0;
        sample_valid = 1'b0;
        check("R10 cal beats sample", 32'(detect), 32'h0);
        sample(2);
        check("R10 integrator cleared", 32'(detect), 32'h0);
        sample(1);
        check("R10 fresh run flags", 32'(detect), 32'h1);
        set_idle();
        sample(1);
    endtask

    initial begin
        set_idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integrator();
        t_hold_and_long();
        t_group();
        t_burst();
        t_away();
        t_cal_priority();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule